// File: doc/BRIEF.md
# I2C Register-Access Slave

This block is the serial front end of a small register bank of sixteen byte-wide registers. It watches the two raw bus lines with the fast system clock and passes each through a two-stage synchronizer and a glitch filter. On the clean lines it detects bus START and STOP conditions and the SCL edges. It answers one fixed 7-bit device address and reads or writes the bank through a simple parallel port. SDA is never driven high: the block only asserts an open-drain enable that pulls the line low.

A write transfer has the device address with R/W = 0, then a pointer byte, then any number of data bytes. The low four bits of the pointer byte select the first register. A read transfer, with R/W = 1, streams registers out from the current pointer. The pointer steps by one after every data byte in either direction and wraps within the bank. For the whole of a read transfer, a freeze output tells the neighbouring time counters to hold still so that a multi-byte read sees one consistent snapshot.

Top module: `i2cs_regbank_slave`

## Requirements
- R1: A STOP (SDA rising while SCL is high) ends the transfer. It releases SDA and drops `freeze_o`. A START (SDA falling while SCL is high) begins matching a new address byte.
- R2: The address byte is seven address bits, MSB first, followed by the R/W bit (0 = write, 1 = read). The block answers only address 7'h51, which gives the bytes 8'hA2 for a write and 8'hA3 for a read. It acknowledges a matching address by holding SDA low through the ninth clock.
- R3: After a non-matching address the block never pulls SDA low and makes no register access until the next START.
- R4: In a write transfer, the byte after the address loads the pointer from its bits [3:0]. Bits [7:4] are ignored. The byte is acknowledged.
- R5: Each received data byte is acknowledged. It produces exactly one single-cycle `reg_wr_o` pulse, with `reg_addr_o` equal to the pointer and `reg_wdata_o` equal to the byte. The pointer then steps by one.
- R6: The pointer wraps from 4'hF to 4'h0 on both writes and reads.
- R7: In a read transfer, the block loads the register at the pointer, pulses `reg_rd_o` and steps the pointer. It then sends the byte MSB first, changing SDA only while SCL is low. The first byte is loaded at the end of the address acknowledge, and each further byte after a master ACK.
- R8: When the master leaves the ninth bit high (NACK) after a read byte, the block releases SDA and sends nothing more until the next START.
- R9: `freeze_o` rises when a read address is acknowledged and stays high until the next STOP or START. It is never high while a write transfer is in progress.
- R10: A repeated START in the middle of a byte drops the partial byte without any register write and restarts address matching.
- R11: A pulse on SCL or SDA that lasts fewer than FILT_LEN system clocks (default 4, i.e. 40 ns at 100 MHz) has no effect.
- R12: `sda_oe_o` is low after reset and starts pulling SDA low only while the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw serial clock line |
| sda_i | input | 1 | Raw serial data line, as seen on the bus |
| sda_oe_o | output | 1 | 1 = pull SDA low, 0 = release |
| reg_addr_o | output | PTR_W | Register pointer, used for both read and write |
| reg_rdata_i | input | 8 | Contents of the register at `reg_addr_o` |
| reg_rd_o | output | 1 | One-cycle pulse when a register byte is taken for sending |
| reg_wr_o | output | 1 | One-cycle register write strobe |
| reg_wdata_o | output | 8 | Write data |
| freeze_o | output | 1 | Hold the time counters during a read transfer |

## Verification
The assertions watch every cycle for the properties that hold locally in time. Write and read strobes are single pulses that advance the pointer with wrap, and writes never coincide with freeze. A read strobe only occurs while freezing. SDA is released after a STOP and while traffic is ignored, and the pull-down only begins while SCL is low. Only the bench's bus scenarios can show the end-to-end behaviour. These are the address decode, the pointer taken from the low nibble, correct byte contents in both directions, the NACK ending a read, a repeated START dropping a half-received byte, and short spikes leaving a transfer unchanged.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ADDR  = 3'd1,
    ST_WORD  = 3'd2,
    ST_WDATA = 3'd3,
    ST_ACK   = 3'd4,
    ST_RDATA = 3'd5,
    ST_RACK  = 3'd6,
    ST_SKIP  = 3'd7
  } xfer_state_t;

endpackage

// File: rtl/i2cs_line_filter.sv
module i2cs_line_filter #(
  parameter int unsigned FILT_LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);

  localparam int unsigned CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;

  logic [1:0]    sync_q;
  logic          flt_q, flt_n;
  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    flt_n = flt_q;
    cnt_n = cnt_q;
    if (sync_q[1] == flt_q) begin
      cnt_n = '0;
    end else if (cnt_q == CW'(FILT_LEN - 1)) begin
      flt_n = sync_q[1];
      cnt_n = '0;
    end else begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      flt_q  <= 1'b1;
      cnt_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], line_i};
      flt_q  <= flt_n;
      cnt_q  <= cnt_n;
    end
  end

  assign line_o = flt_q;

endmodule

// File: rtl/i2cs_bus_events.sv
module i2cs_bus_events (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  logic scl_d_q, sda_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_d_q <= 1'b1;
      sda_d_q <= 1'b1;
    end else begin
      scl_d_q <= scl_i;
      sda_d_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_d_q;
  assign scl_fall_o = ~scl_i & scl_d_q;
  assign start_o    = scl_i & scl_d_q & sda_d_q & ~sda_i;
  assign stop_o     = scl_i & scl_d_q & ~sda_d_q & sda_i;

endmodule

// File: rtl/i2cs_xfer_fsm.sv
module i2cs_xfer_fsm
  import i2cs_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR = 7'h51,
  parameter int unsigned PTR_W    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [BYTE_W-1:0] reg_rdata_i,
  output logic              sda_oe_o,
  output logic [PTR_W-1:0]  reg_addr_o,
  output logic              reg_rd_o,
  output logic              reg_wr_o,
  output logic [BYTE_W-1:0] reg_wdata_o,
  output logic              freeze_o,
  output logic              skip_o
);

  xfer_state_t       state_q, state_n, after_q, after_n;
  logic [3:0]        bit_q, bit_n;
  logic [BYTE_W-1:0] shift_q, shift_n;
  logic [BYTE_W-2:0] tx_q, tx_n;
  logic [PTR_W-1:0]  ptr_q, ptr_n;
  logic              oe_q, oe_n;
  logic              frz_q, frz_n;
  logic              wr_q, wr_n;
  logic              rd_q, rd_n;
  logic              mack_q, mack_n;
  logic [BYTE_W-1:0] wdata_q, wdata_n;

  always_comb begin
    state_n = state_q;
    after_n = after_q;
    bit_n   = bit_q;
    shift_n = shift_q;
    tx_n    = tx_q;
    ptr_n   = ptr_q;
    oe_n    = oe_q;
    frz_n   = frz_q;
    wr_n    = 1'b0;
    rd_n    = 1'b0;
    mack_n  = mack_q;
    wdata_n = wdata_q;

    if (wr_q) ptr_n = ptr_q + 1'b1;

    if (stop_i) begin
      state_n = ST_IDLE;
      oe_n    = 1'b0;
      frz_n   = 1'b0;
    end else if (start_i) begin
      state_n = ST_ADDR;
      bit_n   = '0;
      oe_n    = 1'b0;
      frz_n   = 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_WORD, ST_WDATA: begin
          if (scl_rise_i) begin
            shift_n = {shift_q[BYTE_W-2:0], sda_i};
            bit_n   = bit_q + 1'b1;
          end else if (scl_fall_i && bit_q == 4'd8) begin
            bit_n   = '0;
            after_n = ST_WDATA;
            if (state_q == ST_ADDR) begin
              if (shift_q[7:1] == DEV_ADDR) begin
                oe_n    = 1'b1;
                state_n = ST_ACK;
                after_n = shift_q[0] ? ST_RDATA : ST_WORD;
                frz_n   = shift_q[0];
              end else begin
                state_n = ST_SKIP;
              end
            end else begin
              oe_n    = 1'b1;
              state_n = ST_ACK;
              if (state_q == ST_WORD) begin
                ptr_n = shift_q[PTR_W-1:0];
              end else begin
                wr_n    = 1'b1;
                wdata_n = shift_q;
              end
            end
          end
        end
        ST_ACK: begin
          if (scl_fall_i) begin
            oe_n    = 1'b0;
            bit_n   = '0;
            state_n = after_q;
            if (after_q == ST_RDATA) begin
              tx_n  = reg_rdata_i[BYTE_W-2:0];
              oe_n  = ~reg_rdata_i[BYTE_W-1];
              ptr_n = ptr_q + 1'b1;
              rd_n  = 1'b1;
            end
          end
        end
        ST_RDATA: begin
          if (scl_fall_i) begin
            if (bit_q == 4'd7) begin
              oe_n    = 1'b0;
              state_n = ST_RACK;
            end else begin
              oe_n  = ~tx_q[BYTE_W-2];
              tx_n  = {tx_q[BYTE_W-3:0], 1'b0};
              bit_n = bit_q + 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise_i) begin
            mack_n = ~sda_i;
          end else if (scl_fall_i) begin
            bit_n = '0;
            if (mack_q) begin
              state_n = ST_RDATA;
              tx_n    = reg_rdata_i[BYTE_W-2:0];
              oe_n    = ~reg_rdata_i[BYTE_W-1];
              ptr_n   = ptr_q + 1'b1;
              rd_n    = 1'b1;
            end else begin
              state_n = ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      after_q <= ST_IDLE;
      bit_q   <= '0;
      shift_q <= '0;
      tx_q    <= '0;
      ptr_q   <= '0;
      oe_q    <= 1'b0;
      frz_q   <= 1'b0;
      wr_q    <= 1'b0;
      rd_q    <= 1'b0;
      mack_q  <= 1'b0;
      wdata_q <= '0;
    end else begin
      state_q <= state_n;
      after_q <= after_n;
      bit_q   <= bit_n;
      shift_q <= shift_n;
      tx_q    <= tx_n;
      ptr_q   <= ptr_n;
      oe_q    <= oe_n;
      frz_q   <= frz_n;
      wr_q    <= wr_n;
      rd_q    <= rd_n;
      mack_q  <= mack_n;
      wdata_q <= wdata_n;
    end
  end

  assign sda_oe_o    = oe_q;
  assign reg_addr_o  = ptr_q;
  assign reg_rd_o    = rd_q;
  assign reg_wr_o    = wr_q;
  assign reg_wdata_o = wdata_q;
  assign freeze_o    = frz_q;
  assign skip_o      = (state_q == ST_SKIP);

endmodule

// File: rtl/i2cs_regbank_slave.sv
module i2cs_regbank_slave
  import i2cs_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR = 7'h51,
  parameter int unsigned PTR_W    = 4,
  parameter int unsigned FILT_LEN = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic [PTR_W-1:0]  reg_addr_o,
  input  logic [BYTE_W-1:0] reg_rdata_i,
  output logic              reg_rd_o,
  output logic              reg_wr_o,
  output logic [BYTE_W-1:0] reg_wdata_o,
  output logic              freeze_o
);

  localparam int unsigned N_LINES = 2;

  logic [1:0]         rsync_q;
  logic               rst_int_n;
  logic [N_LINES-1:0] raw_w, flt_w;
  logic               scl_flt, sda_flt;
  logic               scl_rise, scl_fall, start_evt, stop_evt, skip_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rsync_q <= 2'b00;
    else         rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  assign raw_w = {sda_i, scl_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    i2cs_line_filter #(.FILT_LEN(FILT_LEN)) flt_i (
      .clk_i  (clk_i),
      .rst_ni (rst_int_n),
      .line_i (raw_w[g]),
      .line_o (flt_w[g])
    );
  end

  assign scl_flt = flt_w[0];
  assign sda_flt = flt_w[1];

  i2cs_bus_events evt_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_int_n),
    .scl_i      (scl_flt),
    .sda_i      (sda_flt),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_evt),
    .stop_o     (stop_evt)
  );

  i2cs_xfer_fsm #(.DEV_ADDR(DEV_ADDR), .PTR_W(PTR_W)) fsm_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_int_n),
    .sda_i       (sda_flt),
    .scl_rise_i  (scl_rise),
    .scl_fall_i  (scl_fall),
    .start_i     (start_evt),
    .stop_i      (stop_evt),
    .reg_rdata_i (reg_rdata_i),
    .sda_oe_o    (sda_oe_o),
    .reg_addr_o  (reg_addr_o),
    .reg_rd_o    (reg_rd_o),
    .reg_wr_o    (reg_wr_o),
    .reg_wdata_o (reg_wdata_o),
    .freeze_o    (freeze_o),
    .skip_o      (skip_w)
  );

endmodule

// File: rtl/i2cs_regbank_chk.sv
module i2cs_regbank_chk #(
  parameter int unsigned PTR_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sda_oe_o,
  input logic [PTR_W-1:0] reg_addr_o,
  input logic             reg_rd_o,
  input logic             reg_wr_o,
  input logic             freeze_o,
  input logic             scl_flt,
  input logic             stop_evt,
  input logic             skip_w
);

  // R5
  wr_single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |=> !reg_wr_o);

  // R6
  wr_ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |=> reg_addr_o == PTR_W'($past(reg_addr_o) + 1'b1));

  // R7
  rd_single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rd_o |=> !reg_rd_o);

  // R9
  rd_under_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rd_o |-> freeze_o);

  // R9
  no_wr_in_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |-> !freeze_o);

  // R1
  stop_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_evt |=> (!sda_oe_o && !freeze_o));

  // R3
  skip_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_w |-> !sda_oe_o);

  // R12
  pull_on_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_flt);

endmodule

bind i2cs_regbank_slave i2cs_regbank_chk #(.PTR_W(PTR_W)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sda_oe_o   (sda_oe_o),
  .reg_addr_o (reg_addr_o),
  .reg_rd_o   (reg_rd_o),
  .reg_wr_o   (reg_wr_o),
  .freeze_o   (freeze_o),
  .scl_flt    (scl_flt),
  .stop_evt   (stop_evt),
  .skip_w     (skip_w)
);

// File: tb/i2cs_regbank_slave_tb_top.sv
module i2cs_regbank_slave_tb_top;

  localparam int Q = 25;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_oe;
  logic [3:0] reg_addr;
  logic [7:0] reg_rdata, reg_wdata;
  logic       reg_rd, reg_wr, freeze;
  wire        sda_line = sda_m & ~sda_oe;

  logic [7:0] mem [16];
  logic [7:0] exp_mem [16];
  logic [11:0] wq [$];
  int checks = 0, fails = 0, mon_checks = 0, mon_fails = 0;
  int mptr = 0;
  bit done = 0;

  always #5 clk = ~clk;

  i2cs_regbank_slave dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .reg_addr_o(reg_addr), .reg_rdata_i(reg_rdata),
    .reg_rd_o(reg_rd), .reg_wr_o(reg_wr), .reg_wdata_o(reg_wdata),
    .freeze_o(freeze)
  );

  assign reg_rdata = mem[reg_addr];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mem[i] <= 8'(i * 17) ^ 8'hA5;
    end else if (reg_wr) begin
      mem[reg_addr] <= reg_wdata;
    end
  end

  // Per-clock comparison of write strobes against the model's expected writes (R5, R3, R10)
  always @(negedge clk) begin
    if (rst_n && reg_wr) begin
      mon_checks++;
      if (wq.size() == 0) begin
        mon_fails++;
        $display("FAIL R5 unexpected write actual=%0h:%0h expected=none", reg_addr, reg_wdata);
      end else begin
        logic [11:0] e;
        e = wq.pop_front();
        if ({reg_addr, reg_wdata} != e) begin
          mon_fails++;
          $display("FAIL R5 write actual=%0h expected=%0h", {reg_addr, reg_wdata}, e);
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start;
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic i2c_stop;
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(2 * Q);
  endtask

  task automatic clk_bit(input logic b, output logic r);
    sda_m = b;    tick(Q);
    scl_m = 1'b1; tick(Q);
    r = sda_line; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic r;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], r);
    clk_bit(1'b1, r);
    acked = !r;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, r);
      d[i] = r;
    end
    clk_bit(!mack, r);
  endtask

  task automatic wr_data(input logic [7:0] d, input string req);
    logic a;
    wq.push_back({4'(mptr), d});
    exp_mem[mptr] = d;
    send_byte(d, a);
    chk(a, req, a, 1);
    mptr = (mptr + 1) % 16;
  endtask

  task automatic wr_word(input logic [7:0] w);
    logic a;
    send_byte(w, a);
    chk(a, "R4 word ack", a, 1);
    mptr = w[3:0];
  endtask

  task automatic rd_data(input logic mack, input string req);
    logic [7:0] d;
    recv_byte(mack, d);
    chk(d == exp_mem[mptr], req, d, exp_mem[mptr]);
    mptr = (mptr + 1) % 16;
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks + mon_checks, fails + mon_fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish_run();
    end
  end

  initial begin
    logic a, r;
    for (int i = 0; i < 16; i++) exp_mem[i] = 8'(i * 17) ^ 8'hA5;
    tick(4);
    rst_n = 1'b1;
    tick(10);
    // R12 / R9 / R5 reset state
    chk(!sda_oe, "R12 reset oe", sda_oe, 0);
    chk(!freeze, "R9 reset freeze", freeze, 0);
    chk(!reg_wr, "R5 reset wr", reg_wr, 0);

    // Basic write, upper nibble of word byte ignored (R2, R4, R5)
    i2c_start();
    send_byte(8'hA2, a);
    chk(a, "R2 write address ack", a, 1);
    chk(!freeze, "R9 no freeze on write", freeze, 0);
    wr_word(8'h35);
    wr_data(8'h11, "R5 data ack");
    wr_data(8'h22, "R5 data ack");
    wr_data(8'h33, "R5 data ack");
    chk(!freeze, "R9 no freeze during write", freeze, 0);
    i2c_stop();
    chk(!sda_oe && !freeze, "R1 stop release", {sda_oe, freeze}, 0);

    // Pointer wrap on write (R6)
    i2c_start();
    send_byte(8'hA2, a);
    chk(a, "R2 write address ack", a, 1);
    wr_word(8'hFE);
    wr_data(8'hE1, "R6 wrap write");
    wr_data(8'hF2, "R6 wrap write");
    wr_data(8'h03, "R6 wrap write");
    i2c_stop();

    // Set pointer, repeated START into read, wrap on read, NACK (R10, R7, R6, R9, R8)
    i2c_start();
    send_byte(8'hA2, a);
    wr_word(8'h0E);
    i2c_start();
    send_byte(8'hA3, a);
    chk(a, "R10 R2 read address ack after repeated start", a, 1);
    chk(freeze, "R9 freeze during read", freeze, 1);
    rd_data(1'b1, "R7 read byte");
    rd_data(1'b1, "R6 wrap read");
    chk(freeze, "R9 freeze held", freeze, 1);
    rd_data(1'b0, "R7 read byte last");
    clk_bit(1'b1, r);
    chk(r, "R8 released after nack", r, 1);
    i2c_stop();
    chk(!freeze, "R9 freeze dropped at stop", freeze, 0);

    // Read continuing from current pointer (R7)
    i2c_start();
    send_byte(8'hA3, a);
    chk(a, "R2 read address ack", a, 1);
    rd_data(1'b1, "R7 continued read");
    rd_data(1'b0, "R7 continued read");
    i2c_stop();

    // Wrong address ignored (R3)
    i2c_start();
    send_byte(8'hA4, a);
    chk(!a, "R3 no ack wrong address", a, 0);
    send_byte(8'h02, a);
    chk(!a, "R3 no ack after mismatch", a, 0);
    send_byte(8'h55, a);
    chk(!a, "R3 no ack after mismatch", a, 0);
    i2c_stop();

    // Repeated START mid byte drops partial byte (R10)
    i2c_start();
    send_byte(8'hA2, a);
    wr_word(8'h07);
    clk_bit(1'b1, r); clk_bit(1'b1, r); clk_bit(1'b0, r);
    i2c_start();
    send_byte(8'hA2, a);
    chk(a, "R10 restart address ack", a, 1);
    wr_word(8'h08);
    wr_data(8'h5A, "R10 data after restart");
    i2c_stop();

    // SDA spike while idle must not act as START (R11)
    tick(Q);
    sda_m = 1'b0; tick(2);
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b0; tick(Q);
    send_byte(8'hA2, a);
    chk(!a, "R11 sda spike not a start", a, 0);
    i2c_stop();

    // SCL spike inside a data byte must not add a bit (R11)
    i2c_start();
    send_byte(8'hA2, a);
    wr_word(8'h0A);
    begin
      logic [7:0] d;
      d = 8'hC3;
      wq.push_back({4'(mptr), d});
      exp_mem[mptr] = d;
      for (int i = 7; i >= 0; i--) begin
        clk_bit(d[i], r);
        if (i == 4) begin
          tick(5);
          scl_m = 1'b1; tick(2);
          scl_m = 1'b0; tick(5);
        end
      end
      clk_bit(1'b1, r);
      chk(!r, "R11 scl spike byte ack", r, 0);
      mptr = (mptr + 1) % 16;
    end
    i2c_stop();
    tick(20);

    // Whole bank content (R5)
    for (int i = 0; i < 16; i++)
      chk(mem[i] == exp_mem[i], "R5 bank content", mem[i], exp_mem[i]);

    done = 1;
    finish_run();
  end

endmodule